// File: doc/BRIEF.md
# Minute Time-Base Divider

This block turns a slow event train, typically a squared mains waveform at 60 Hz, into one single-cycle output pulse for every 3600 events. At 60 Hz that is one pulse per minute. The event line is brought into the system clock domain through a synchronizer. A falling-edge detector then gives a one-cycle enable to a fourteen-stage binary counter.

The counter is fully synchronous, so its decode cannot glitch. A four-input AND decode watches the stages of weight 16, 512, 1024 and 2048. Those weights add up to 3600, and no smaller count has all four set. When the decode fires, a terminal flag is raised. On the next clock the counter is cleared and the output pulse is driven. Twelve of the fourteen stages are visible on an output bus for observation; the stages of weight 2 and 4 stay internal.

Top module: `tbase_minute_divider`

## Requirements
- R1: Each high-to-low transition of `ev_i` advances the count by exactly one. If `ev_i` changes between clock edges, the new count is visible after the third rising `clk` edge that follows the change.
- R2: A low-to-high transition of `ev_i` leaves the count unchanged.
- R3: Driving `rst_n` low clears every stage, `tc_o` and `pulse_o` at once, without waiting for a clock. A falling edge of `ev_i` that occurs while `rst_n` is low, or whose low level is already present when reset is released, is never counted.
- R4: Stage n, counting from 1, carries weight 2^(n-1). The counter therefore holds the binary number of events counted since the last clear.
- R5: `vis_o` bit 0 is stage 1, and `vis_o` bits 1 to 11 are stages 4 to 14 in ascending order. Stages 2 and 3 never appear on `vis_o`.
- R6: `tc_o` is high in exactly those cycles in which stages 5, 10, 11 and 12 are all high. This is the count 3600, and it is low for every count from 0 to 3599.
- R7: In the cycle after `tc_o` is high, `pulse_o` is high for exactly one clock and the count is zero. The next falling edge gives a count of 1.
- R8: Outside reset, `pulse_o` rises once per 3600 falling edges of `ev_i` and at no other time. The count never exceeds 3600.
- R9: A reset asserted in the cycle in which `tc_o` is high suppresses the pulse that would have followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_i | input | 1 | Asynchronous event input; counted on falling edges |
| pulse_o | output | 1 | One-clock pulse every 3600 events |
| vis_o | output | 12 | Visible stages: bit 0 = stage 1, bits 1..11 = stages 4..14 |
| tc_o | output | 1 | Terminal-count flag (count equals 3600) |

## Verification
Two events can meet in the same cycle: the terminal-count clear with its pulse, and an asynchronous reset. The bench brings the count to 3600 and confirms that `tc_o` is high. It then pulls `rst_n` low in the middle of that same clock cycle, before the edge that would clear the counter and raise the pulse. It judges the result by seeing all outputs go to zero at once, `pulse_o` staying low on the following edge, and no pulse being counted. Counting is then shown to restart from one after reset is released.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Number of set bits in a stage mask.
  function automatic int mask_ones(input logic [31:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) n++;
    end
    return n;
  endfunction

  // Bit position of the k-th set bit (k from 0) of a stage mask.
  function automatic int mask_pos(input logic [31:0] m, input int k);
    int seen;
    int pos;
    seen = 0;
    pos  = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        if (seen == k) pos = i;
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/tbase_rst_sync.sv
module tbase_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] rq_q;
  logic [1:0] rq_d;

  always_comb begin
    rq_d = {rq_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q <= 2'b00;
    end else begin
      rq_q <= rq_d;
    end
  end

  assign rst_ns = rq_q[1];

endmodule

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
  parameter int SYNC_FLOPS = 2
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic ev_i,
  output logic fall_o
);

  localparam int LAST = SYNC_FLOPS - 1;

  logic [SYNC_FLOPS-1:0] sync_q;
  logic [SYNC_FLOPS-1:0] sync_d;
  logic                  prev_q;
  logic                  prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_FLOPS-2:0], ev_i};
    prev_d = sync_q[LAST];
  end

  // Reset value low on both: a reset never manufactures a falling edge.
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  // R1: one edge yields a single-cycle enable
  a_r1_single_fall: assert property (@(posedge clk) disable iff (!rst_ns)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int STAGES = 14
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] cnt_o
);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic [STAGES-1:0] carry;

  // Per-stage toggle chain: stage i toggles when enabled and all lower stages are high.
  assign carry[0] = en_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i < STAGES - 1) begin : g_carry
      assign carry[i+1] = carry[i] & cnt_q[i];
    end
    always_comb begin
      if (clr_i) begin
        cnt_d[i] = 1'b0;
      end else begin
        cnt_d[i] = cnt_q[i] ^ carry[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R1, R4: an enable without clear adds exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_ns)
    (en_i && !clr_i) |=> (cnt_q == $past(cnt_q) + {{(STAGES-1){1'b0}}, 1'b1}));

  // R2: no enable, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_tc_decode.sv
module tbase_tc_decode #(
  parameter int              STAGES  = 14,
  parameter logic [31:0]     TC_MASK = 32'h0000_0E10
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic [STAGES-1:0] cnt_i,
  output logic              tc_o,
  output logic              clr_o,
  output logic              pulse_o
);

  localparam logic [STAGES-1:0] TCM = TC_MASK[STAGES-1:0];

  logic tc;
  logic pulse_q;
  logic pulse_d;

  // Counter is synchronous, so this AND of register outputs is glitch-free at the edge.
  always_comb begin
    tc      = &(cnt_i | ~TCM);
    pulse_d = tc;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign tc_o    = tc;
  assign clr_o   = tc;
  assign pulse_o = pulse_q;

  // R7: the pulse is one clock wide
  a_r7_one_wide: assert property (@(posedge clk) disable iff (!rst_ns)
    pulse_q |=> !pulse_q);

  // R7: counter is zero once the terminal cycle has passed
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_ns)
    tc |=> (cnt_i == '0));

  // R8: a pulse only ever follows a terminal cycle
  a_r8_pulse_src: assert property (@(posedge clk) disable iff (!rst_ns)
    pulse_q |-> $past(tc));

endmodule

// File: rtl/tbase_minute_divider.sv
module tbase_minute_divider #(
  parameter int          STAGES     = 14,
  parameter int          SYNC_FLOPS = 2,
  parameter logic [31:0] TC_MASK    = 32'h0000_0E10,
  parameter logic [31:0] VIS_MASK   = 32'h0000_3FF9,
  localparam int         VIS_W      = tbase_pkg::mask_ones(VIS_MASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  output logic             pulse_o,
  output logic [VIS_W-1:0] vis_o,
  output logic             tc_o
);

  localparam logic [STAGES-1:0] TC_VAL = TC_MASK[STAGES-1:0];

  logic              rst_ns;
  logic              fall_en;
  logic              clr;
  logic [STAGES-1:0] cnt_w;

  tbase_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  tbase_edge_sync #(
    .SYNC_FLOPS (SYNC_FLOPS)
  ) u_edge (
    .clk    (clk),
    .rst_ns (rst_ns),
    .ev_i   (ev_i),
    .fall_o (fall_en)
  );

  tbase_counter #(
    .STAGES (STAGES)
  ) u_cnt (
    .clk    (clk),
    .rst_ns (rst_ns),
    .en_i   (fall_en),
    .clr_i  (clr),
    .cnt_o  (cnt_w)
  );

  tbase_tc_decode #(
    .STAGES  (STAGES),
    .TC_MASK (TC_MASK)
  ) u_dec (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .cnt_i   (cnt_w),
    .tc_o    (tc_o),
    .clr_o   (clr),
    .pulse_o (pulse_o)
  );

  // Bring out only the stages selected by VIS_MASK, lowest first.
  for (genvar k = 0; k < VIS_W; k++) begin : g_vis
    localparam int SRC = tbase_pkg::mask_pos(VIS_MASK, k);
    assign vis_o[k] = cnt_w[SRC];
  end

  // R8: the count never runs past the terminal value
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_ns)
    cnt_w <= TC_VAL);

  // R6: terminal flag and clear arrive together with a counter that only grew by enable
  a_r6_tc_via_step: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(tc_o) |-> $past(fall_en));

endmodule

// File: tb/tbase_minute_divider_tb.sv
module tbase_minute_divider_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TERM       = 3600;
  localparam int NVEC       = 11;
  // {falling edges to apply, expected count afterwards}
  localparam int VEC [NVEC][2] = '{
    '{1, 1}, '{1, 2}, '{1, 3}, '{1, 4}, '{3, 7}, '{1, 8},
    '{8, 16}, '{16, 32}, '{480, 512}, '{1536, 2048}, '{1551, 3599}
  };

  logic        clk;
  logic        rst_n;
  logic        ev_i;
  logic        pulse_o;
  logic [11:0] vis_o;
  logic        tc_o;

  int checks;
  int failures;
  int pulse_cnt;

  tbase_minute_divider u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev_i),
    .pulse_o (pulse_o),
    .vis_o   (vis_o),
    .tc_o    (tc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (pulse_o) pulse_cnt++;
  end

  // R5: visible bus = {stages 14..4, stage 1}
  function automatic logic [11:0] vis_of(input int c);
    logic [13:0] v;
    v = 14'(c);
    return {v[13:3], v[0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall_lo();
    @(negedge clk);
    ev_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rise_hi();
    ev_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic full_fall(input int n);
    for (int i = 0; i < n; i++) begin
      fall_lo();
      rise_hi();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks    = 0;
    failures  = 0;
    pulse_cnt = 0;
    rst_n     = 1'b0;
    ev_i      = 1'b1;
    #2;
    check(vis_o == 12'd0, "R3 reset vis", vis_o, 0);
    check(tc_o == 1'b0 && pulse_o == 1'b0, "R3 reset tc/pulse", {tc_o, pulse_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      full_fall(VEC[v][0]);
      check(vis_o == vis_of(VEC[v][1]), "R4/R5 count on vis", vis_o, vis_of(VEC[v][1]));
      check(tc_o == 1'b0, "R6 no terminal below 3600", tc_o, 0);
    end
    check(pulse_cnt == 0, "R8 no early pulse", pulse_cnt, 0);

    // Terminal count, clear and pulse: R6, R7
    fall_lo();
    check(tc_o == 1'b1, "R6 terminal flag at 3600", tc_o, 1);
    check(vis_o == vis_of(TERM), "R6 vis at 3600", vis_o, vis_of(TERM));
    check(pulse_o == 1'b0, "R7 pulse not before clear", pulse_o, 0);
    @(negedge clk);
    check(pulse_o == 1'b1, "R7 pulse after terminal", pulse_o, 1);
    check(vis_o == 12'd0 && tc_o == 1'b0, "R7 cleared", vis_o, 0);
    @(negedge clk);
    check(pulse_o == 1'b0, "R7 pulse one clock", pulse_o, 0);
    rise_hi();
    check(vis_o == 12'd0, "R2 rising edge ignored at zero", vis_o, 0);

    // R1 latency and R2 rising edge
    @(negedge clk);
    ev_i = 1'b0;
    repeat (2) @(negedge clk);
    check(vis_o == 12'd0, "R1 not before third edge", vis_o, 0);
    @(negedge clk);
    check(vis_o == vis_of(1), "R1 restart from zero", vis_o, vis_of(1));
    rise_hi();
    check(vis_o == vis_of(1), "R2 rising edge ignored", vis_o, vis_of(1));

    // R8: exactly one pulse per 3600 edges
    pulse_cnt = 0;
    full_fall(TERM - 2);
    check(pulse_cnt == 0, "R8 none before 3600", pulse_cnt, 0);
    check(vis_o == vis_of(TERM - 1), "R8 count 3599", vis_o, vis_of(TERM - 1));
    full_fall(1);
    check(pulse_cnt == 1, "R8 one pulse per 3600", pulse_cnt, 1);
    check(vis_o == 12'd0, "R8 cleared after period", vis_o, 0);

    // R3: mid-count asynchronous reset
    full_fall(100);
    check(vis_o == vis_of(100), "R3 count before reset", vis_o, vis_of(100));
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(vis_o == 12'd0, "R3 async clear", vis_o, 0);
    full_fall(3);
    check(vis_o == 12'd0, "R3 edges in reset ignored", vis_o, 0);
    ev_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rise_hi();
    check(vis_o == 12'd0, "R3 low level at release ignored", vis_o, 0);
    full_fall(1);
    check(vis_o == vis_of(1), "R3 counting resumes", vis_o, vis_of(1));

    // R9: reset in the terminal cycle suppresses the pulse
    full_fall(TERM - 2);
    pulse_cnt = 0;
    fall_lo();
    check(tc_o == 1'b1, "R9 terminal reached", tc_o, 1);
    #1 rst_n = 1'b0;
    #1 check(tc_o == 1'b0 && vis_o == 12'd0, "R9 reset clears at terminal", vis_o, 0);
    @(negedge clk);
    check(pulse_o == 1'b0, "R9 pulse suppressed", pulse_o, 0);
    check(pulse_cnt == 0, "R9 no pulse counted", pulse_cnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rise_hi();
    full_fall(1);
    check(vis_o == vis_of(1), "R9 count restarts", vis_o, vis_of(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule